// File: doc/BRIEF.md
# Flash Command Interrupt Status Unit

This unit holds the host-facing command, status, interrupt and system-configuration registers of a flash controller. A host reaches it through a plain register bus with a write strobe, an offset and write data. Reads are combinational and are selected by the offset.

A command write is accepted only when no interrupt is pending. An accepted command that the execution engine handles goes out on a one-cycle issue strobe. A reset command is handled inside the unit as a warm reset. Any other code is rejected and flagged as a command error.

The execution engine reports back with a completion strobe. The strobe carries a class code and a failure flag. The unit turns these into interrupt bits and error bits. It drives an interrupt pin whose polarity is set by a configuration bit, and a ready pin that software sets through the same configuration register.

Top module: `flctl_cmd_irq_unit`

## Requirements
- R1: After the synchronous reset `rst` (cold reset), the registers read as follows: interrupt 0x8080, config-1 0x40C0, config-2 0x0000, status 0x0000, command 0x0000. `ready_o` is 1. Register offsets: command 0, config-1 1, config-2 2, status 3, interrupt 4. Any other offset reads 0.
- R2: While interrupt bit 15 is set, a write to the command register is ignored. `cmd_issue` stays low and the command register keeps its value.
- R3: Code 0x0000, 0x0013, 0x0080, 0x001A, 0x001B, 0x0023, 0x0027, 0x002A, 0x002C, 0x0030, 0x0065, 0x0071, 0x0094, 0x0095 or 0x00B0, written while bit 15 is clear, is stored in the command register. It is issued with `cmd_issue` high for exactly the cycle after the write, and `cmd_code` carries the code.
- R4: Any other code written while bit 15 is clear, apart from the reset codes, sets status bit 10 and interrupt bit 15 and is not issued.
- R5: When `done_valid` is high, interrupt bit 15 is set on that edge. With it, the bit for the class is set: class 1 (erase) sets bit 5, class 2 (program) sets bit 6, class 3 (load) sets bit 7, and class 0 sets no class bit.
- R6: When `done_valid` and `done_fail` are both high, status bit 10 is set. With it, the error bit for the class is set: erase sets bit 11, program sets bit 12, load sets bit 13.
- R7: A write to the interrupt register replaces it with the bitwise AND of its old value and the written data.
- R8: After a write to the interrupt register, status bits 10 to 13 are cleared if bit 15 of the result is 0. They are kept if bit 15 is 1.
- R9: `irq_o` equals interrupt bit 15 XOR the inverse of config-1 bit 6.
- R10: On each config-1 write, `ready_o` takes bit 7 of the written value.
- R11: A read of config-1 returns the stored value with bits 4 to 0 forced to 0. Config-2 reads back exactly as written.
- R12: Code 0x00F0 or 0x00F3, written while bit 15 is clear, is a warm reset. Interrupt becomes 0x8010. Config-1, config-2, status and command return to their R1 values and `ready_o` becomes 1. Nothing is issued.
- R13: If a completion and an interrupt-register write fall on the same edge, the AND is applied first and the completion bits are then set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| cmd_issue | output | 1 | One-cycle strobe for a command sent to the engine |
| cmd_code | output | 16 | Code of the issued command |
| done_valid | input | 1 | Completion strobe from the engine |
| done_class | input | 2 | Completion class: 0 none, 1 erase, 2 program, 3 load |
| done_fail | input | 1 | Completion ended in error |
| irq_o | output | 1 | Interrupt pin, polarity set by config-1 bit 6 |
| ready_o | output | 1 | Ready pin |

## Verification
Each register effect of a write or a completion takes hold at the rising edge that samples it. The register can therefore be read back from the falling edge that follows. The bench drives every stimulus on a falling edge and reads on a later falling edge through the combinational read port.

`cmd_issue` is high only between the edge that accepts a command and the next edge. For that reason the issue strobe is sampled at the falling edge straight after the write, before any other bus operation. `irq_o` and `ready_o` are combinational from registers and are sampled on the same falling-edge grid.

// File: rtl/flctl_pkg.sv
package flctl_pkg;

    localparam int DW = 16;
    localparam int AW = 3;

    // register offsets
    localparam logic [AW-1:0] OFS_CMD  = 3'd0;
    localparam logic [AW-1:0] OFS_CFG1 = 3'd1;
    localparam logic [AW-1:0] OFS_CFG2 = 3'd2;
    localparam logic [AW-1:0] OFS_STAT = 3'd3;
    localparam logic [AW-1:0] OFS_INT  = 3'd4;

    // interrupt register bits
    localparam int INT_PEND_BIT  = 15;
    localparam int INT_RST_BIT   = 4;
    localparam int INT_ERASE_BIT = 5;
    localparam int INT_PROG_BIT  = 6;
    localparam int INT_LOAD_BIT  = 7;

    // status register bits
    localparam int ERR_CMD_BIT   = 10;
    localparam int ERR_ERASE_BIT = 11;
    localparam int ERR_PROG_BIT  = 12;
    localparam int ERR_LOAD_BIT  = 13;

    // config-1 bits
    localparam int CFG_POL_BIT = 6;
    localparam int CFG_RDY_BIT = 7;

    localparam logic [DW-1:0] PEND_MASK    = DW'(1) << INT_PEND_BIT;
    localparam logic [DW-1:0] ERR_ALL_MASK = (DW'(1) << ERR_CMD_BIT) | (DW'(1) << ERR_ERASE_BIT)
                                           | (DW'(1) << ERR_PROG_BIT) | (DW'(1) << ERR_LOAD_BIT);
    localparam logic [DW-1:0] INT_COLD_VAL = PEND_MASK | (DW'(1) << INT_LOAD_BIT);
    localparam logic [DW-1:0] INT_WARM_VAL = PEND_MASK | (DW'(1) << INT_RST_BIT);
    localparam logic [DW-1:0] CFG1_RST_VAL = 16'h40C0;
    localparam logic [DW-1:0] CFG1_RD_MASK = 16'hFFE0;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ERASE = 2'd1,
        CLS_PROG  = 2'd2,
        CLS_LOAD  = 2'd3
    } done_class_e;

    typedef enum logic [1:0] {
        CMD_ENGINE,
        CMD_WARM_RESET,
        CMD_UNKNOWN
    } cmd_kind_e;

    function automatic cmd_kind_e classify_cmd(input logic [DW-1:0] code);
        case (code)
            16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
            16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0030,
            16'h0065, 16'h0071, 16'h0094, 16'h0095, 16'h00B0:
                return CMD_ENGINE;
            16'h00F0, 16'h00F3:
                return CMD_WARM_RESET;
            default:
                return CMD_UNKNOWN;
        endcase
    endfunction

    function automatic logic [DW-1:0] class_int_bits(input done_class_e cls);
        case (cls)
            CLS_ERASE: return DW'(1) << INT_ERASE_BIT;
            CLS_PROG:  return DW'(1) << INT_PROG_BIT;
            CLS_LOAD:  return DW'(1) << INT_LOAD_BIT;
            default:   return '0;
        endcase
    endfunction

    function automatic logic [DW-1:0] class_err_bits(input done_class_e cls);
        case (cls)
            CLS_ERASE: return DW'(1) << ERR_ERASE_BIT;
            CLS_PROG:  return DW'(1) << ERR_PROG_BIT;
            CLS_LOAD:  return DW'(1) << ERR_LOAD_BIT;
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/flctl_cmd_decode.sv
module flctl_cmd_decode
    import flctl_pkg::*;
(
    input  logic [DW-1:0] code,
    output cmd_kind_e     kind
);
    always_comb begin
        kind = classify_cmd(code);
    end
endmodule

// File: rtl/flctl_cfg_regs.sv
module flctl_cfg_regs
    import flctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          warm,
    input  logic          cfg1_wr,
    input  logic          cfg2_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cfg1_q,
    output logic [DW-1:0] cfg2_q,
    output logic          ready_q
);
    always_ff @(posedge clk) begin
        if (rst || warm) begin
            cfg1_q  <= CFG1_RST_VAL;
            cfg2_q  <= '0;
            ready_q <= 1'b1;
        end else begin
            if (cfg1_wr) begin
                cfg1_q  <= wdata;
                ready_q <= wdata[CFG_RDY_BIT];
            end
            if (cfg2_wr) begin
                cfg2_q <= wdata;
            end
        end
    end

    // R10
    rdy_follows_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg1_wr && !warm) |=> (ready_q == $past(wdata[CFG_RDY_BIT])));

    // R12
    cfg_warm_chk: assert property (@(posedge clk) disable iff (rst)
        warm |=> (cfg1_q == CFG1_RST_VAL && cfg2_q == '0 && ready_q));
endmodule

// File: rtl/flctl_irq_regs.sv
module flctl_irq_regs
    import flctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          warm,
    input  logic          int_wr,
    input  logic [DW-1:0] wdata,
    input  logic          cmd_reject,
    input  logic          done_valid,
    input  logic [1:0]    done_class,
    input  logic          done_fail,
    output logic [DW-1:0] int_q,
    output logic [DW-1:0] stat_q
);
    done_class_e   cls;
    logic [DW-1:0] int_n;
    logic [DW-1:0] stat_n;

    always_comb begin
        cls    = done_class_e'(done_class);
        int_n  = int_q;
        stat_n = stat_q;
        // the AND-clear comes first, so set bits from this cycle survive it
        if (int_wr) begin
            int_n = int_n & wdata;
        end
        if (done_valid) begin
            int_n = int_n | PEND_MASK | class_int_bits(cls);
            if (done_fail) begin
                stat_n = stat_n | (DW'(1) << ERR_CMD_BIT) | class_err_bits(cls);
            end
        end
        if (cmd_reject) begin
            int_n  = int_n | PEND_MASK;
            stat_n = stat_n | (DW'(1) << ERR_CMD_BIT);
        end
        if (int_wr && !int_n[INT_PEND_BIT]) begin
            stat_n = stat_n & ~ERR_ALL_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            int_q  <= INT_COLD_VAL;
            stat_q <= '0;
        end else if (warm) begin
            int_q  <= INT_WARM_VAL;
            stat_q <= '0;
        end else begin
            int_q  <= int_n;
            stat_q <= stat_n;
        end
    end

    // R5
    done_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (done_valid && !warm) |=> (int_q[INT_PEND_BIT]
            && ((int_q & class_int_bits(done_class_e'($past(done_class))))
                == class_int_bits(done_class_e'($past(done_class))))));

    // R8
    err_wipe_chk: assert property (@(posedge clk) disable iff (rst)
        (int_wr && !wdata[INT_PEND_BIT] && !done_valid && !cmd_reject && !warm)
            |=> ((stat_q & ERR_ALL_MASK) == '0));

    // R12
    irq_warm_chk: assert property (@(posedge clk) disable iff (rst)
        warm |=> (int_q == INT_WARM_VAL && stat_q == '0));
endmodule

// File: rtl/flctl_cmd_irq_unit.sv
module flctl_cmd_irq_unit
    import flctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          cmd_issue,
    output logic [DW-1:0] cmd_code,
    input  logic          done_valid,
    input  logic [1:0]    done_class,
    input  logic          done_fail,
    output logic          irq_o,
    output logic          ready_o
);
    logic [DW-1:0] int_q, stat_q, cfg1_q, cfg2_q, cmd_q;
    logic          issue_q;
    cmd_kind_e     kind;
    logic          cmd_accept, go_engine, go_warm, go_reject;

    flctl_cmd_decode u_dec (
        .code (bus_wdata),
        .kind (kind)
    );

    assign cmd_accept = bus_wr && (bus_addr == OFS_CMD) && !int_q[INT_PEND_BIT];
    assign go_engine  = cmd_accept && (kind == CMD_ENGINE);
    assign go_warm    = cmd_accept && (kind == CMD_WARM_RESET);
    assign go_reject  = cmd_accept && (kind == CMD_UNKNOWN);

    flctl_irq_regs u_irq (
        .clk        (clk),
        .rst        (rst),
        .warm       (go_warm),
        .int_wr     (bus_wr && bus_addr == OFS_INT),
        .wdata      (bus_wdata),
        .cmd_reject (go_reject),
        .done_valid (done_valid),
        .done_class (done_class),
        .done_fail  (done_fail),
        .int_q      (int_q),
        .stat_q     (stat_q)
    );

    flctl_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .warm    (go_warm),
        .cfg1_wr (bus_wr && bus_addr == OFS_CFG1),
        .cfg2_wr (bus_wr && bus_addr == OFS_CFG2),
        .wdata   (bus_wdata),
        .cfg1_q  (cfg1_q),
        .cfg2_q  (cfg2_q),
        .ready_q (ready_o)
    );

    always_ff @(posedge clk) begin
        if (rst || go_warm) begin
            cmd_q   <= '0;
            issue_q <= 1'b0;
        end else begin
            issue_q <= go_engine;
            if (go_engine || go_reject) begin
                cmd_q <= bus_wdata;
            end
        end
    end

    assign cmd_issue = issue_q;
    assign cmd_code  = cmd_q;
    assign irq_o     = int_q[INT_PEND_BIT] ^ ~cfg1_q[CFG_POL_BIT];

    always_comb begin
        case (bus_addr)
            OFS_CMD:  bus_rdata = cmd_q;
            OFS_CFG1: bus_rdata = cfg1_q & CFG1_RD_MASK;
            OFS_CFG2: bus_rdata = cfg2_q;
            OFS_STAT: bus_rdata = stat_q;
            OFS_INT:  bus_rdata = int_q;
            default:  bus_rdata = '0;
        endcase
    end

    // R2
    gated_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CMD && int_q[INT_PEND_BIT]) |=> (!cmd_issue && $stable(cmd_code)));

    // R3
    issue_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_issue |=> !cmd_issue);

    // R4
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        go_reject |=> (!cmd_issue && stat_q[ERR_CMD_BIT] && int_q[INT_PEND_BIT]));
endmodule

// File: tb/flctl_cmd_irq_unit_bench.sv
module flctl_cmd_irq_unit_bench;
    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] OP_W   = 3'd0; // write addr,val
    localparam logic [2:0] OP_RD  = 3'd1; // read addr expect val
    localparam logic [2:0] OP_ISS = 3'd2; // cmd_issue == val[0]
    localparam logic [2:0] OP_IRQ = 3'd3; // irq_o == val[0]
    localparam logic [2:0] OP_RDY = 3'd4; // ready_o == val[0]

    typedef struct packed {
        logic [2:0]  op;
        logic [2:0]  addr;
        logic [15:0] val;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 40;
    localparam vec_t TBL [NV] = '{
        '{OP_RD,  3'd4, 16'h8080, 4'd1},  // R1 interrupt
        '{OP_RD,  3'd1, 16'h40C0, 4'd1},  // R1 config-1
        '{OP_RD,  3'd3, 16'h0000, 4'd1},  // R1 status
        '{OP_RD,  3'd6, 16'h0000, 4'd1},  // R1 unmapped
        '{OP_RDY, 3'd0, 16'h0001, 4'd1},  // R1 ready
        '{OP_IRQ, 3'd0, 16'h0001, 4'd9},  // R9 pend=1, pol=1
        '{OP_W,   3'd0, 16'h0094, 4'd2},  // R2 gated
        '{OP_ISS, 3'd0, 16'h0000, 4'd2},  // R2
        '{OP_RD,  3'd0, 16'h0000, 4'd2},  // R2 command unchanged
        '{OP_W,   3'd4, 16'h7FFF, 4'd7},  // R7 AND
        '{OP_RD,  3'd4, 16'h0080, 4'd7},  // R7
        '{OP_IRQ, 3'd0, 16'h0000, 4'd9},  // R9
        '{OP_W,   3'd0, 16'h0094, 4'd3},  // R3 erase code
        '{OP_ISS, 3'd0, 16'h0001, 4'd3},  // R3
        '{OP_RD,  3'd0, 16'h0094, 4'd3},  // R3
        '{OP_W,   3'd0, 16'h0013, 4'd3},  // R3 second code
        '{OP_ISS, 3'd0, 16'h0001, 4'd3},  // R3
        '{OP_RD,  3'd0, 16'h0013, 4'd3},  // R3
        '{OP_W,   3'd1, 16'h0000, 4'd10}, // R10 ready low, polarity 0
        '{OP_RDY, 3'd0, 16'h0000, 4'd10}, // R10
        '{OP_IRQ, 3'd0, 16'h0001, 4'd9},  // R9 inverted polarity
        '{OP_RD,  3'd1, 16'h0000, 4'd11}, // R11
        '{OP_W,   3'd1, 16'h00FF, 4'd11}, // R11 low bits set
        '{OP_RD,  3'd1, 16'h00E0, 4'd11}, // R11 masked
        '{OP_RDY, 3'd0, 16'h0001, 4'd10}, // R10
        '{OP_IRQ, 3'd0, 16'h0000, 4'd9},  // R9
        '{OP_W,   3'd2, 16'h1234, 4'd11}, // R11 config-2
        '{OP_RD,  3'd2, 16'h1234, 4'd11}, // R11
        '{OP_W,   3'd0, 16'h0055, 4'd4},  // R4 unknown code
        '{OP_ISS, 3'd0, 16'h0000, 4'd4},  // R4
        '{OP_RD,  3'd3, 16'h0400, 4'd4},  // R4
        '{OP_RD,  3'd4, 16'h8080, 4'd4},  // R4
        '{OP_W,   3'd4, 16'h00FF, 4'd8},  // R8 clear pend
        '{OP_RD,  3'd3, 16'h0000, 4'd8},  // R8
        '{OP_RD,  3'd4, 16'h0080, 4'd7},  // R7
        '{OP_W,   3'd0, 16'h00F0, 4'd12}, // R12 warm reset
        '{OP_ISS, 3'd0, 16'h0000, 4'd12}, // R12
        '{OP_RD,  3'd4, 16'h8010, 4'd12}, // R12
        '{OP_RD,  3'd1, 16'h40C0, 4'd12}, // R12
        '{OP_RD,  3'd2, 16'h0000, 4'd12}  // R12
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        cmd_issue;
    logic [15:0] cmd_code;
    logic        done_valid = 1'b0;
    logic [1:0]  done_class = '0;
    logic        done_fail = 1'b0;
    logic        irq_o, ready_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flctl_cmd_irq_unit u_flctl_cmd_irq_unit (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_issue(cmd_issue),
        .cmd_code(cmd_code), .done_valid(done_valid), .done_class(done_class),
        .done_fail(done_fail), .irq_o(irq_o), .ready_o(ready_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [15:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic done(input logic [1:0] c, input logic f);
        @(negedge clk);
        done_valid = 1'b1; done_class = c; done_fail = f;
        @(negedge clk);
        done_valid = 1'b0; done_fail = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", TBL[i].req, i);
            case (TBL[i].op)
                OP_W:   wr(TBL[i].addr, TBL[i].val);
                OP_RD:  rd_chk(tag, TBL[i].addr, TBL[i].val);
                OP_ISS: begin #1; check(tag, {15'd0, cmd_issue}, TBL[i].val); end
                OP_IRQ: begin #1; check(tag, {15'd0, irq_o}, TBL[i].val); end
                default: begin #1; check(tag, {15'd0, ready_o}, TBL[i].val); end
            endcase
        end

        // R5 program completion without failure
        wr(3'd4, 16'h0000);
        done(2'd2, 1'b0);
        rd_chk("R5 prog", 3'd4, 16'h8040);
        rd_chk("R5 status untouched", 3'd3, 16'h0000);
        // R6 failing load completion
        wr(3'd4, 16'h0000);
        done(2'd3, 1'b1);
        rd_chk("R6 load err", 3'd3, 16'h2400);
        rd_chk("R5 load", 3'd4, 16'h8080);
        // R8 pend kept: errors stay
        wr(3'd4, 16'hFFFF);
        rd_chk("R8 keep", 3'd3, 16'h2400);
        wr(3'd4, 16'h0000);
        rd_chk("R8 wipe", 3'd3, 16'h0000);
        // R6 failing class-0 completion
        done(2'd0, 1'b1);
        rd_chk("R6 none err", 3'd3, 16'h0400);
        rd_chk("R5 none", 3'd4, 16'h8000);
        wr(3'd4, 16'h0000);
        // R13 completion and interrupt write on the same edge
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 16'h0000;
        done_valid = 1'b1; done_class = 2'd1; done_fail = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0; done_valid = 1'b0;
        rd_chk("R13 erase survives", 3'd4, 16'h8020);
        // R12 second reset code after clearing
        wr(3'd4, 16'h0000);
        wr(3'd0, 16'h00F3);
        #1; check("R12 no issue", {15'd0, cmd_issue}, 16'h0000);
        rd_chk("R12 F3", 3'd4, 16'h8010);
        // R1 cold reset after activity
        wr(3'd2, 16'hABCD);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_chk("R1 cold int", 3'd4, 16'h8080);
        rd_chk("R1 cold cfg2", 3'd2, 16'h0000);
        summary();
    end
endmodule